// File: doc/BRIEF.md
# MDIO Management Master

This block is a bus master for the two-wire MDIO management interface used to configure Ethernet PHYs. It produces the MDC clock from the system clock, shifts complete management frames onto the MDIO line and samples read data back from the PHY. Both Clause 22 and Clause 45 framing are available. The MDIO line is split into an output value, an output enable and an input, so that the pad ring or a testbench can build the open line.

Software uses a 32-bit register port with sixteen word slots. Only the top four slots hold registers. Slot 12 holds configuration and status, slot 13 holds the command, slot 14 holds data and slot 15 holds the Clause 45 register address. Every frame is started by a register write. A write to the address slot in Clause 45 mode sends an address frame. A write to the data slot sends a write frame. A command write with its read bit set sends a read frame. While a frame runs, a busy flag is set. When a read finishes, the captured word appears in the data slot. A read-error flag reports that no PHY answered during the turnaround.

Top module: `mdio_master`

## Requirements
- R1: After reset, the configuration slot (12) reads 0x0000_0280. That is the divider field at bits 15:7 equal to 5, with every flag clear. The command, data and address slots read zero.
- R2: Slots 0 to 11 always read zero, and writes to them change no register.
- R3: In Clause 22 mode (bit 6 of slot 12 clear), a write to slot 14 sends 32 ones of preamble and then this frame: start 01, opcode 01, five PHY bits from slot 13 bits 9:5, five register bits from slot 13 bits 4:0, turnaround 10, and the 16 written data bits. All fields go MSB first.
- R4: A write to slot 13 with bit 15 set sends a read frame using that write's address fields. In Clause 22 the opcode is 10. The 16 bits the PHY returns are then readable in slot 14 bits 15:0. Bit 15 of slot 13 always reads back as zero.
- R5: In Clause 45 mode (bit 6 set), a write to slot 15 sends start 00, opcode 00 and the 16-bit register address in the data field, with turnaround 10. In Clause 22 mode, a write to slot 15 only stores the value and sends nothing.
- R6: Clause 45 write frames use start 00 and opcode 01. Clause 45 read frames use start 00 and opcode 11.
- R7: If the line is high at the second turnaround bit of a read, slot 12 bit 1 is set. It stays set until the next read frame starts.
- R8: With slot 12 bit 5 set, the preamble is left out and a frame is exactly 32 MDC periods long.
- R9: One MDC period is 2*d+1 system clocks. Here d is the divider field, and any value below 5 is treated as 5. Busy (slot 12 bit 0) stays high for exactly (frame bits)*(2*d+1) cycles.
- R10: Busy reads 1 in the cycle after a triggering write. While busy is set, writes to slots 13, 14 and 15 are dropped entirely.
- R11: MDC stays high between frames. During a read, the master releases MDIO (enable low) from the first turnaround bit through the last data bit.
- R12: MDIO changes just after a falling MDC edge and is sampled at the rising edge. Every bit is therefore stable at the rising MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word slot for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the slot on reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Sampled MDIO line |
| mdio_o | output | 1 | Driven MDIO value |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
The assertions assume one register access per cycle. They also assume that the configuration slot is not rewritten while a frame is in flight, because the divider is latched at frame start but the flags are read live. They further assume the PHY drives MDIO only in the turnaround and data bits of a read. The stimulus keeps to all three assumptions: it polls busy until it clears before touching configuration, and its PHY responder counts falling MDC edges so that it starts driving exactly at the second turnaround bit. The bench also flags any cycle in which master and responder drive the line together.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W    = 16;
  localparam int FRAME_W   = 32;
  localparam int PRE_W     = 32;
  localparam int DIV_W     = 9;
  localparam int DIV_MIN   = 5;
  localparam int REL_FIRST = 17;   // frame bit index of first turnaround bit
  localparam int TA_SAMPLE = 16;   // frame bit index of second turnaround bit

  localparam logic [3:0] SLOT_CFG = 4'd12;
  localparam logic [3:0] SLOT_CMD = 4'd13;
  localparam logic [3:0] SLOT_DAT = 4'd14;
  localparam logic [3:0] SLOT_ADR = 4'd15;

  typedef enum logic [1:0] {
    FR_ADDR  = 2'd0,
    FR_WRITE = 2'd1,
    FR_READ  = 2'd2
  } frame_kind_e;

  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : d;
  endfunction

  function automatic logic [1:0] opcode_of(input logic c45, input frame_kind_e k);
    case (k)
      FR_ADDR:  return 2'b00;
      FR_WRITE: return 2'b01;
      default:  return c45 ? 2'b11 : 2'b10;
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic c45, input frame_kind_e k,
                                                     input logic [4:0] port, input logic [4:0] dev,
                                                     input logic [DATA_W-1:0] payload);
    return {(c45 ? 2'b00 : 2'b01), opcode_of(c45, k), port, dev, 2'b10, payload};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             end_stb
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_c;
  logic [CNT_W-1:0] last_c;
  logic             mdc_q;

  assign half_c = {1'b0, half};
  assign last_c = {half, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b1;
    end else begin
      if (!run || cnt_q == last_c) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
      mdc_q <= !(run && cnt_q < half_c);
    end
  end

  assign mdc      = mdc_q;
  assign fall_stb = run && (cnt_q == '0);
  assign rise_stb = run && (cnt_q == half_c);
  assign end_stb  = run && (cnt_q == last_c);

  // R9: the clamped divider keeps the three phase events apart
  assert_phase_distinct_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb, end_stb}))
    else $error("phase strobes coincide");
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] start_frame,
  input  logic               start_read,
  input  logic               start_nopre,
  input  logic [DIV_W-1:0]   start_div,
  input  logic               mdio_i,
  output logic               busy,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               rd_done,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_err
);
  localparam int IDX_W = $clog2(FRAME_W + PRE_W);

  logic               busy_q, read_q, o_q, oe_q, err_q, done_q;
  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic [DATA_W-1:0]  rx_q;
  logic [DIV_W-1:0]   div_q;

  logic fall_evt, rise_evt, end_evt;
  logic in_pre, cur_bit, released;

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .half     (div_q),
    .mdc      (mdc),
    .fall_stb (fall_evt),
    .rise_stb (rise_evt),
    .end_stb  (end_evt)
  );

  assign in_pre   = idx_q[IDX_W-1];
  assign cur_bit  = in_pre ? 1'b1 : frame_q[idx_q[IDX_W-2:0]];
  assign released = read_q && !in_pre && (idx_q[IDX_W-2:0] <= (IDX_W-1)'(REL_FIRST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      read_q  <= 1'b0;
      o_q     <= 1'b1;
      oe_q    <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      frame_q <= '0;
      idx_q   <= '0;
      rx_q    <= '0;
      div_q   <= DIV_W'(DIV_MIN);
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q  <= 1'b1;
        frame_q <= start_frame;
        read_q  <= start_read;
        div_q   <= clamp_div(start_div);
        idx_q   <= start_nopre ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W + PRE_W - 1);
        if (start_read) err_q <= 1'b0;
      end else if (busy_q) begin
        if (fall_evt) begin
          o_q  <= released ? 1'b1 : cur_bit;
          oe_q <= !released;
        end
        if (rise_evt && read_q && !in_pre) begin
          if (idx_q[IDX_W-2:0] == (IDX_W-1)'(TA_SAMPLE) && mdio_i) err_q <= 1'b1;
          if (idx_q[IDX_W-2:0] < (IDX_W-1)'(DATA_W)) rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        end
        if (end_evt) begin
          if (idx_q == '0) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
            o_q    <= 1'b1;
            done_q <= read_q;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign rd_done = done_q;
  assign rd_data = rx_q;
  assign rd_err  = err_q;

  // R10: the register port never launches a frame over a running one
  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q)
    else $error("start while busy");

  // R11: line stays released through the second turnaround and data bits
  assert_read_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && read_q && !in_pre && idx_q[IDX_W-2:0] < (IDX_W-1)'(REL_FIRST)) |-> !oe_q)
    else $error("master drives during read data");

  // R4: completion of capture only for read frames
  assert_done_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (read_q && !busy_q))
    else $error("read completion on non-read frame");
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter logic [8:0] DIV_RESET = 9'd5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic               pre_off_q, c45_q;
  logic [DIV_W-1:0]   div_q;
  logic [4:0]         dev_q, port_q;
  logic [DATA_W-1:0]  data_q, adr_q;

  logic               eng_busy, eng_done, eng_err;
  logic [DATA_W-1:0]  eng_rx;

  logic               wr_cfg, wr_cmd, wr_dat, wr_adr;
  logic               trig;
  frame_kind_e        kind;
  logic [4:0]         f_port, f_dev;
  logic [DATA_W-1:0]  f_payload;
  logic [FRAME_W-1:0] f_frame;

  assign wr_cfg = reg_wr && reg_addr == SLOT_CFG;
  assign wr_cmd = reg_wr && reg_addr == SLOT_CMD && !eng_busy;
  assign wr_dat = reg_wr && reg_addr == SLOT_DAT && !eng_busy;
  assign wr_adr = reg_wr && reg_addr == SLOT_ADR && !eng_busy;

  always_comb begin
    trig      = 1'b0;
    kind      = FR_WRITE;
    f_port    = port_q;
    f_dev     = dev_q;
    f_payload = reg_wdata[DATA_W-1:0];
    if (wr_cmd && reg_wdata[15]) begin
      trig      = 1'b1;
      kind      = FR_READ;
      f_port    = reg_wdata[9:5];
      f_dev     = reg_wdata[4:0];
      f_payload = '1;
    end else if (wr_dat) begin
      trig = 1'b1;
      kind = FR_WRITE;
    end else if (wr_adr && c45_q) begin
      trig = 1'b1;
      kind = FR_ADDR;
    end
    f_frame = build_frame(c45_q, kind, f_port, f_dev, f_payload);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_off_q <= 1'b0;
      c45_q     <= 1'b0;
      div_q     <= DIV_RESET;
      dev_q     <= '0;
      port_q    <= '0;
      data_q    <= '0;
      adr_q     <= '0;
    end else begin
      if (wr_cfg) begin
        pre_off_q <= reg_wdata[5];
        c45_q     <= reg_wdata[6];
        div_q     <= reg_wdata[15:7];
      end
      if (wr_cmd) begin
        dev_q  <= reg_wdata[4:0];
        port_q <= reg_wdata[9:5];
      end
      if (wr_dat)        data_q <= reg_wdata[DATA_W-1:0];
      else if (eng_done) data_q <= eng_rx;
      if (wr_adr) adr_q <= reg_wdata[DATA_W-1:0];
    end
  end

  mdio_frame_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (trig),
    .start_frame (f_frame),
    .start_read  (kind == FR_READ),
    .start_nopre (pre_off_q),
    .start_div   (div_q),
    .mdio_i      (mdio_i),
    .busy        (eng_busy),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .rd_done     (eng_done),
    .rd_data     (eng_rx),
    .rd_err      (eng_err)
  );

  always_comb begin
    case (reg_addr)
      SLOT_CFG: reg_rdata = {16'b0, div_q, c45_q, pre_off_q, 3'b0, eng_err, eng_busy};
      SLOT_CMD: reg_rdata = {16'b0, 6'b0, port_q, dev_q};
      SLOT_DAT: reg_rdata = {16'b0, data_q};
      SLOT_ADR: reg_rdata = {16'b0, adr_q};
      default:  reg_rdata = '0;
    endcase
  end

  // R2: reserved slots return zero
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < SLOT_CFG) |-> (reg_rdata == '0))
    else $error("reserved slot not zero");

  // R11: clock parked high between frames
  assert_mdc_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_busy && !$past(eng_busy)) |-> mdc)
    else $error("MDC low while idle");
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam logic [3:0] CFG = 4'd12, CMD = 4'd13, DAT = 4'd14, ADR = 4'd15;

  typedef struct {
    logic [63:0] bits;
    int          len;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_line;
  logic        phy_en = 1'b0, phy_bit = 1'b1;

  int   n_chk = 0, n_bad = 0;
  bit   finished = 0;
  exp_t sb_q[$];
  logic [63:0] mon_sh = '0;
  int   mon_cnt = 0;

  // responder controls
  bit          rsp_read = 0, rsp_answer = 0;
  logic [15:0] rsp_data = '0;
  int          rsp_pre = 32, rsp_falls = 0;

  always #10 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_i(mdio_line), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] cfg_word(input logic [8:0] d, input bit c45, input bit nopre);
    return {16'b0, d, c45, nopre, 5'b0};
  endfunction

  function automatic logic [31:0] wr_frame(input bit c45, input logic [1:0] op, input logic [4:0] pa,
                                           input logic [4:0] da, input logic [15:0] v);
    logic [1:0] st;
    st = c45 ? 2'b00 : 2'b01;
    return {st, op, pa, da, 2'b10, v};
  endfunction

  function automatic logic [31:0] rd_frame(input bit c45, input logic [4:0] pa, input logic [4:0] da,
                                           input bit answered, input logic [15:0] v);
    logic [1:0] op;
    op = c45 ? 2'b11 : 2'b10;
    if (answered) return {(c45 ? 2'b00 : 2'b01), op, pa, da, 2'b10, v};
    return {(c45 ? 2'b00 : 2'b01), op, pa, da, 2'b11, 16'hFFFF};
  endfunction

  task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  // drive one triggering write, queue the expected line bits, time busy
  task automatic run_frame(input logic [3:0] a, input logic [31:0] d, input logic [31:0] fr,
                           input bit nopre, input int period, input bit is_rd, input bit ans,
                           input logic [15:0] pdat, input string tag);
    exp_t e;
    int   n;
    e.bits = nopre ? {32'h0, fr} : {32'hFFFF_FFFF, fr};
    e.len  = nopre ? 32 : 64;
    e.tag  = tag;
    sb_q.push_back(e);
    rsp_read = is_rd; rsp_answer = ans; rsp_data = pdat;
    rsp_pre = nopre ? 0 : 32; rsp_falls = 0;
    write_reg(a, d);
    reg_addr = CFG;
    #1;
    chk(reg_rdata[0] == 1'b1, {tag, " R10 busy after trigger"}, 64'(reg_rdata[0]), 64'd1);
    n = 0;
    while (reg_rdata[0] == 1'b1) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk(n == e.len * period, {tag, " R9 busy length"}, 64'(n), 64'(e.len * period));
    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, {tag, " R12 frame consumed"}, 64'(sb_q.size()), 64'd0);
    rsp_read = 0;
  endtask

  // PHY responder: counts falling MDC edges
  always @(negedge mdc) begin
    if (rst_n) begin
      int j;
      rsp_falls++;
      j = rsp_falls - 1 - rsp_pre;
      if (rsp_read && rsp_answer) begin
        if (j == 15) begin
          phy_en = 1'b1; phy_bit = 1'b0;
        end else if (j >= 16 && j <= 31) begin
          phy_bit = rsp_data[31 - j];
        end
      end
      #1;
      if (rsp_read && j >= 14 && j <= 31)
        chk(mdio_oe == 1'b0, "R11 master released in read", 64'(mdio_oe), 64'd0);
      if (mdio_oe && phy_en)
        chk(1'b0, "R11 bus contention", 64'd1, 64'd0);
    end
  end

  // monitor: collect bits at rising MDC and compare against the queue
  always @(posedge mdc) begin
    if (rst_n) begin
      mon_sh = {mon_sh[62:0], mdio_line};
      mon_cnt++;
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 unexpected MDC edge", 64'(mon_cnt), 64'd0);
        mon_cnt = 0;
      end else if (mon_cnt == sb_q[0].len) begin
        logic [63:0] mask;
        mask = (sb_q[0].len == 64) ? '1 : 64'h0000_0000_FFFF_FFFF;
        chk((mon_sh & mask) == sb_q[0].bits, {sb_q[0].tag, " frame bits"}, mon_sh & mask, sb_q[0].bits);
        void'(sb_q.pop_front());
        mon_cnt = 0;
        phy_en = 1'b0; phy_bit = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    read_reg(CFG, v); chk(v == 32'h0000_0280, "R1 cfg reset", 64'(v), 64'h280);
    read_reg(CMD, v); chk(v == 32'h0, "R1 cmd reset", 64'(v), 64'h0);
    read_reg(DAT, v); chk(v == 32'h0, "R1 data reset", 64'(v), 64'h0);
    read_reg(ADR, v); chk(v == 32'h0, "R1 addr reset", 64'(v), 64'h0);
    chk(mdc == 1'b1 && mdio_oe == 1'b0, "R11 idle line", {62'b0, mdc, mdio_oe}, 64'h2);

    // R2 reserved slots
    write_reg(4'd3, 32'hFFFF_FFFF);
    write_reg(4'd11, 32'hFFFF_FFFF);
    read_reg(4'd3, v);  chk(v == 32'h0, "R2 slot3 zero", 64'(v), 64'h0);
    read_reg(4'd11, v); chk(v == 32'h0, "R2 slot11 zero", 64'(v), 64'h0);
    read_reg(CFG, v);   chk(v == 32'h0000_0280, "R2 cfg untouched", 64'(v), 64'h280);
    read_reg(DAT, v);   chk(v == 32'h0, "R2 data untouched", 64'(v), 64'h0);

    // Clause 22 addressing, command write without read bit sends nothing
    write_reg(CMD, {22'b0, 5'h05, 5'h0A});
    repeat (30) @(negedge clk);
    read_reg(CFG, v); chk(v[0] == 1'b0, "R4 cmd without read bit idle", 64'(v[0]), 64'd0);
    read_reg(CMD, v); chk(v == 32'h0000_00AA, "R4 cmd fields", 64'(v), 64'hAA);

    // R3 Clause 22 write, default divider 5 -> 11 clocks per bit
    run_frame(DAT, 32'h0000_BEEF, wr_frame(0, 2'b01, 5'h05, 5'h0A, 16'hBEEF), 0, 11, 0, 0, 16'h0, "R3 c22 write");
    read_reg(DAT, v); chk(v == 32'h0000_BEEF, "R3 data kept", 64'(v), 64'hBEEF);

    // R4 Clause 22 read
    run_frame(CMD, {16'b0, 1'b1, 5'b0, 5'h05, 5'h0A}, rd_frame(0, 5'h05, 5'h0A, 1, 16'h1234), 0, 11, 1, 1, 16'h1234, "R4 c22 read");
    read_reg(DAT, v); chk(v == 32'h0000_1234, "R4 captured data", 64'(v), 64'h1234);
    read_reg(CFG, v); chk(v[1] == 1'b0, "R7 no error on answered read", 64'(v[1]), 64'd0);
    read_reg(CMD, v); chk(v[15] == 1'b0, "R4 read bit reads zero", 64'(v[15]), 64'd0);

    // R7 unanswered read, then error cleared by next read
    run_frame(CMD, {16'b0, 1'b1, 5'b0, 5'h1F, 5'h02}, rd_frame(0, 5'h1F, 5'h02, 0, 16'h0), 0, 11, 1, 0, 16'h0, "R7 no phy");
    read_reg(CFG, v); chk(v[1] == 1'b1, "R7 error set", 64'(v[1]), 64'd1);
    run_frame(CMD, {16'b0, 1'b1, 5'b0, 5'h1F, 5'h02}, rd_frame(0, 5'h1F, 5'h02, 1, 16'hA5C3), 0, 11, 1, 1, 16'hA5C3, "R7 retry");
    read_reg(CFG, v); chk(v[1] == 1'b0, "R7 error cleared", 64'(v[1]), 64'd0);
    read_reg(DAT, v); chk(v == 32'h0000_A5C3, "R4 second capture", 64'(v), 64'hA5C3);

    // R5 address slot in Clause 22 mode: stored only
    write_reg(ADR, 32'h0000_0042);
    repeat (40) @(negedge clk);
    read_reg(CFG, v); chk(v[0] == 1'b0, "R5 c22 addr no frame", 64'(v[0]), 64'd0);
    chk(mon_cnt == 0, "R5 no MDC activity", 64'(mon_cnt), 64'd0);
    read_reg(ADR, v); chk(v == 32'h0000_0042, "R5 addr stored", 64'(v), 64'h42);

    // R10 writes while busy are dropped
    write_reg(CMD, {22'b0, 5'h05, 5'h0A});
    sb_q.push_back('{bits: {32'hFFFF_FFFF, wr_frame(0, 2'b01, 5'h05, 5'h0A, 16'h1111)}, len: 64, tag: "R10 first frame"});
    rsp_read = 0; rsp_pre = 32; rsp_falls = 0;
    write_reg(DAT, 32'h0000_1111);
    write_reg(DAT, 32'h0000_2222);
    write_reg(CMD, 32'h0000_8063);
    write_reg(ADR, 32'h0000_7777);
    reg_addr = CFG; #1;
    while (reg_rdata[0] == 1'b1) begin @(negedge clk); #1; end
    repeat (60) @(negedge clk);
    chk(sb_q.size() == 0 && mon_cnt == 0, "R10 single frame", 64'(mon_cnt), 64'd0);
    read_reg(DAT, v); chk(v == 32'h0000_1111, "R10 data not overwritten", 64'(v), 64'h1111);
    read_reg(CMD, v); chk(v == 32'h0000_00AA, "R10 cmd not overwritten", 64'(v), 64'hAA);
    read_reg(ADR, v); chk(v == 32'h0000_0042, "R10 addr not overwritten", 64'(v), 64'h42);

    // R5 R6 Clause 45
    write_reg(CFG, cfg_word(9'd5, 1, 0));
    write_reg(CMD, {22'b0, 5'h03, 5'h01});
    run_frame(ADR, 32'h0000_C042, wr_frame(1, 2'b00, 5'h03, 5'h01, 16'hC042), 0, 11, 0, 0, 16'h0, "R5 c45 address");
    run_frame(DAT, 32'h0000_5A5A, wr_frame(1, 2'b01, 5'h03, 5'h01, 16'h5A5A), 0, 11, 0, 0, 16'h0, "R6 c45 write");
    run_frame(CMD, {16'b0, 1'b1, 5'b0, 5'h03, 5'h01}, rd_frame(1, 5'h03, 5'h01, 1, 16'hC0DE), 0, 11, 1, 1, 16'hC0DE, "R6 c45 read");
    read_reg(DAT, v); chk(v == 32'h0000_C0DE, "R6 c45 captured", 64'(v), 64'hC0DE);

    // R8 R9 preamble off, divider 7 -> 15 clocks per bit
    write_reg(CFG, cfg_word(9'd7, 1, 1));
    read_reg(CFG, v); chk(v == cfg_word(9'd7, 1, 1), "R8 cfg readback", 64'(v), 64'(cfg_word(9'd7, 1, 1)));
    run_frame(DAT, 32'h0000_0F0F, wr_frame(1, 2'b01, 5'h03, 5'h01, 16'h0F0F), 1, 15, 0, 0, 16'h0, "R8 no preamble");
    run_frame(CMD, {16'b0, 1'b1, 5'b0, 5'h07, 5'h1E}, rd_frame(1, 5'h07, 5'h1E, 1, 16'h8001), 1, 15, 1, 1, 16'h8001, "R8 short read");
    read_reg(DAT, v); chk(v == 32'h0000_8001, "R8 short read data", 64'(v), 64'h8001);

    // R9 divider below minimum clamped to 5, Clause 22 short frame
    write_reg(CFG, cfg_word(9'd2, 0, 1));
    run_frame(DAT, 32'h0000_3C3C, wr_frame(0, 2'b01, 5'h07, 5'h1E, 16'h3C3C), 1, 11, 0, 0, 16'h0, "R9 clamp");
    write_reg(CFG, cfg_word(9'd0, 0, 1));
    run_frame(DAT, 32'h0000_0001, wr_frame(0, 2'b01, 5'h07, 5'h1E, 16'h0001), 1, 11, 0, 0, 16'h0, "R9 clamp zero");

    repeat (10) @(negedge clk);
    chk(mdc == 1'b1 && mdio_oe == 1'b0, "R11 idle after frames", {62'b0, mdc, mdio_oe}, 64'h2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule